// File: doc/BRIEF.md
# Receive Character Queue with Status Flags

This block sits between a serial receiver's shift register and the data register that a bus master reads. Each character the receiver completes arrives with a one-cycle strobe, nine data bits and three error bits (parity, framing, noise). Characters are queued in order. The oldest one is presented in a holding register, and every read of that register brings the next character forward.

The block reports several status flags. A not-empty flag shows that a character is available. A full flag shows that the queue and the holding register are both occupied. A programmable fill-level flag shows that the chosen amount of storage is in use. A sticky overrun flag records that a character was lost. The three error flags always describe the character currently in the holding register, because the error bits travel through the queue with their character.

A flush request discards everything that is stored. Each sticky flag has its own write-one-to-clear input.

Top module: `rxq_core`

## Requirements
- R1: After reset, not_empty, full, thr_hit, ovr, pe_flag, fe_flag and ne_flag are all 0. One cycle after a character is accepted into empty storage, not_empty is 1 and rd_data shows that character.
- R2: Characters leave in the order they arrived. Each rd_en pulse while not_empty is 1 removes exactly one character, and the next one appears on rd_data in the following cycle.
- R3: A read and an accepted write in the same cycle leave the stored count unchanged. A read while not_empty is 0 changes nothing, and rd_data keeps its last value.
- R4: A flush pulse empties all storage, so not_empty and full are 0 in the next cycle. A character that arrives in the same cycle as the flush is dropped.
- R5: full is 1 exactly when the number of stored characters equals DEPTH + 1, which means the queue holds DEPTH characters and the holding register holds one more.
- R6: thr_hit is 1 when the stored count, holding register included, is at least the level chosen by thr_cfg. The codes map as follows: 0 gives DEPTH/8, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives 3·DEPTH/4, 4 gives 7·DEPTH/8, and 5 to 7 give DEPTH. The level is never below 1.
- R7: A character that arrives while full is 1 is discarded, the stored contents are left untouched, and ovr is set in the next cycle. With DEPTH = 16, the 17th character does not overrun and the 18th does.
- R8: While ovr_off is 1, ovr is cleared and held at 0. Characters that arrive while full are still discarded.
- R9: pe_flag, fe_flag and ne_flag equal the error bits that arrived with the character currently on rd_data. Here rx_perr is the parity error bit, rx_ferr the framing error bit and rx_nerr the noise bit.
- R10: A pulse on clr_pe, clr_fe, clr_ne or clr_ore clears only its own flag (pe_flag, fe_flag, ne_flag or ovr) in the next cycle. A flag being set in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Character-complete strobe from the receiver |
| rx_data | input | 9 | Received character |
| rx_perr | input | 1 | Parity error bit of the character |
| rx_ferr | input | 1 | Framing error bit of the character |
| rx_nerr | input | 1 | Noise bit of the character |
| rd_en | input | 1 | Read strobe for the holding register |
| flush | input | 1 | Discard all stored characters |
| ovr_off | input | 1 | Disable overrun detection |
| thr_cfg | input | 3 | Fill-level code |
| clr_pe | input | 1 | Clear the parity error flag |
| clr_fe | input | 1 | Clear the framing error flag |
| clr_ne | input | 1 | Clear the noise flag |
| clr_ore | input | 1 | Clear the overrun flag |
| rd_data | output | 9 | Holding register contents |
| not_empty | output | 1 | At least one character is readable |
| full | output | 1 | DEPTH + 1 characters are stored |
| thr_hit | output | 1 | Fill level reached |
| ovr | output | 1 | Sticky overrun flag |
| pe_flag | output | 1 | Parity error of the head character |
| fe_flag | output | 1 | Framing error of the head character |
| ne_flag | output | 1 | Noise flag of the head character |

## Verification
The properties assume that every input is a clean, synchronous single-cycle level. They also assume that the clear inputs are meant to act only on the character already in the holding register, which is why the clear property is gated by the absence of a holding-register load and of a flush. The stimulus drives all inputs half a cycle away from the sampling edge. It raises each strobe for exactly one cycle, except where a read and a write are deliberately made to coincide. It keeps thr_cfg steady within each fill sweep, so that every fill-level comparison is made against a single level.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int CHAR_W = 9;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              nerr;
  } rxq_entry_t;

  // Fill level selected by the 3-bit code, counted including the holding register.
  function automatic int thr_level(input logic [2:0] code, input int depth);
    int lvl;
    case (code)
      3'd0:    lvl = depth >> 3;
      3'd1:    lvl = depth >> 2;
      3'd2:    lvl = depth >> 1;
      3'd3:    lvl = (depth >> 1) + (depth >> 2);
      3'd4:    lvl = depth - (depth >> 3);
      default: lvl = depth;
    endcase
    if (lvl < 1) lvl = 1;
    return lvl;
  endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic                           pop,
  input  rxq_entry_t                     din,
  output rxq_entry_t                     head,
  output logic [$clog2(DEPTH+1)-1:0]     cnt
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rxq_entry_t     mem [DEPTH];
  logic [AW-1:0]  wp;
  logic [AW-1:0]  rp;
  logic [CW-1:0]  cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign head = mem[rp];
  assign cnt  = cnt_q;

endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  rxq_entry_t        src,
  input  logic              clr_pe,
  input  logic              clr_fe,
  input  logic              clr_ne,
  output logic [CHAR_W-1:0] data,
  output logic              valid,
  output logic              pe,
  output logic              fe,
  output logic              ne
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else if (load) data <= src.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid <= 1'b0;
    else if (clear) valid <= 1'b0;
    else if (load)  valid <= 1'b1;
  end

  // Error flags are taken from the entry when it loads; each clears on its own strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe <= 1'b0;
      fe <= 1'b0;
      ne <= 1'b0;
    end else if (clear) begin
      pe <= 1'b0;
      fe <= 1'b0;
      ne <= 1'b0;
    end else if (load) begin
      pe <= src.perr;
      fe <= src.ferr;
      ne <= src.nerr;
    end else begin
      if (clr_pe) pe <= 1'b0;
      if (clr_fe) fe <= 1'b0;
      if (clr_ne) ne <= 1'b0;
    end
  end

endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic dis,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (dis)  flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

endmodule

// File: rtl/rxq_core.sv
module rxq_core
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [8:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_nerr,
  input  logic              rd_en,
  input  logic              flush,
  input  logic              ovr_off,
  input  logic [2:0]        thr_cfg,
  input  logic              clr_pe,
  input  logic              clr_fe,
  input  logic              clr_ne,
  input  logic              clr_ore,
  output logic [8:0]        rd_data,
  output logic              not_empty,
  output logic              full,
  output logic              thr_hit,
  output logic              ovr,
  output logic              pe_flag,
  output logic              fe_flag,
  output logic              ne_flag
);

  localparam int CAP = DEPTH + 1;
  localparam int FCW = $clog2(DEPTH + 1);
  localparam int CW  = $clog2(CAP + 1);

  rxq_entry_t     in_ent;
  rxq_entry_t     head_ent;
  rxq_entry_t     hold_src;
  logic [FCW-1:0] fifo_cnt;
  logic           fifo_empty;
  logic           hold_v;
  logic [CW-1:0]  fill;
  logic [CW-1:0]  lvl;

  // Named internal events, observed by the checker.
  logic acc;
  logic pop;
  logic fifo_push;
  logic fifo_pop;
  logic hold_load;
  logic hold_clear;
  logic overrun_evt;

  assign in_ent = '{data: rx_data, perr: rx_perr, ferr: rx_ferr, nerr: rx_nerr};

  assign fill       = CW'(fifo_cnt) + CW'(hold_v);
  assign full       = (fill == CW'(CAP));
  assign fifo_empty = (fifo_cnt == '0);

  assign acc         = rx_valid && !full && !flush;
  assign pop         = rd_en && hold_v && !flush;
  assign overrun_evt = rx_valid && full;

  assign hold_load  = (pop && (!fifo_empty || acc)) || (!hold_v && acc);
  assign hold_src   = (pop && !fifo_empty) ? head_ent : in_ent;
  assign hold_clear = flush || (pop && !hold_load);
  assign fifo_pop   = pop && !fifo_empty;
  assign fifo_push  = acc && hold_v && !(pop && fifo_empty);

  assign lvl     = CW'(thr_level(thr_cfg, DEPTH));
  assign thr_hit = (fill >= lvl);

  rxq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .din   (in_ent),
    .head  (head_ent),
    .cnt   (fifo_cnt)
  );

  rxq_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hold_load),
    .clear  (hold_clear),
    .src    (hold_src),
    .clr_pe (clr_pe),
    .clr_fe (clr_fe),
    .clr_ne (clr_ne),
    .data   (rd_data),
    .valid  (hold_v),
    .pe     (pe_flag),
    .fe     (fe_flag),
    .ne     (ne_flag)
  );

  rxq_ovr u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (overrun_evt),
    .clr   (clr_ore),
    .dis   (ovr_off),
    .flag  (ovr)
  );

  assign not_empty = hold_v;

endmodule

// File: rtl/rxq_core_chk.sv
module rxq_core_chk #(
  parameter int DEPTH = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rx_valid,
  input logic                          rd_en,
  input logic                          flush,
  input logic                          ovr_off,
  input logic                          clr_pe,
  input logic [8:0]                    rd_data,
  input logic                          not_empty,
  input logic                          full,
  input logic                          thr_hit,
  input logic                          ovr,
  input logic                          pe_flag,
  input logic                          acc,
  input logic                          pop,
  input logic                          hold_load,
  input logic [$clog2(DEPTH+2)-1:0]    fill
);

  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!not_empty && !full));

  a_r3_rdwr_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && acc) |=> (fill == $past(fill)));

  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && !rx_valid) |=> (!not_empty && $stable(rd_data)));

  a_r6_full_over_thr: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> thr_hit);

  a_r7_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !ovr_off) |=> ovr);

  a_r7_keep_contents: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !rd_en && !flush) |=> (full && $stable(rd_data)));

  a_r8_ovr_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_off |=> !ovr);

  a_r10_clr_pe: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pe && !hold_load && !flush) |=> !pe_flag);

endmodule

bind rxq_core rxq_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rd_en     (rd_en),
  .flush     (flush),
  .ovr_off   (ovr_off),
  .clr_pe    (clr_pe),
  .rd_data   (rd_data),
  .not_empty (not_empty),
  .full      (full),
  .thr_hit   (thr_hit),
  .ovr       (ovr),
  .pe_flag   (pe_flag),
  .acc       (acc),
  .pop       (pop),
  .hold_load (hold_load),
  .fill      (fill)
);

// File: tb/rxq_core_test.sv
module rxq_core_test;

  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_perr, rx_ferr, rx_nerr;
  logic [8:0] rx_data;
  logic       rd_en, flush, ovr_off;
  logic [2:0] thr_cfg;
  logic       clr_pe, clr_fe, clr_ne, clr_ore;
  logic [8:0] rd_data;
  logic       not_empty, full, thr_hit, ovr, pe_flag, fe_flag, ne_flag;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rxq_core #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_nerr(rx_nerr),
    .rd_en(rd_en), .flush(flush), .ovr_off(ovr_off), .thr_cfg(thr_cfg),
    .clr_pe(clr_pe), .clr_fe(clr_fe), .clr_ne(clr_ne), .clr_ore(clr_ore),
    .rd_data(rd_data), .not_empty(not_empty), .full(full), .thr_hit(thr_hit),
    .ovr(ovr), .pe_flag(pe_flag), .fe_flag(fe_flag), .ne_flag(ne_flag)
  );

  function automatic int lvl_of(input int cfg);
    int eighths;
    eighths = (cfg == 0) ? 1 : (cfg == 1) ? 2 : (cfg == 2) ? 4 :
              (cfg == 3) ? 6 : (cfg == 4) ? 7 : 8;
    return ((D * eighths) / 8 < 1) ? 1 : (D * eighths) / 8;
  endfunction

  function automatic logic [8:0] pat(input int k, input int c);
    return 9'((k * 37 + c * 5) % 512);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [8:0] d, input logic [2:0] e);
    rx_valid = 1'b1; rx_data = d;
    rx_perr = e[2]; rx_ferr = e[1]; rx_nerr = e[0];
    tick();
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_nerr = 1'b0;
  endtask

  task automatic take();
    rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1; tick(); flush = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [8:0] keep;
    int n;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_perr = 1'b0; rx_ferr = 1'b0;
    rx_nerr = 1'b0; rd_en = 1'b0; flush = 1'b0; ovr_off = 1'b0; thr_cfg = 3'd0;
    clr_pe = 1'b0; clr_fe = 1'b0; clr_ne = 1'b0; clr_ore = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 reset not_empty", not_empty, 0);
    chk("R1 reset full", full, 0);
    chk("R1 reset thr_hit", thr_hit, 0);
    chk("R1 reset ovr", ovr, 0);
    chk("R1 reset err flags", {pe_flag, fe_flag, ne_flag}, 0);

    // R1 first character
    put(9'h1A5, 3'b100);
    chk("R1 not_empty after write", not_empty, 1);
    chk("R1 rd_data", rd_data, 9'h1A5);
    chk("R9 pe of head", pe_flag, 1);

    // R5 R6 sweep over every fill-level code and every fill count
    for (int c = 0; c < 8; c++) begin
      thr_cfg = 3'(c);
      do_flush();
      for (int k = 1; k <= D + 1; k++) begin
        put(pat(k, c), 3'(k));
        chk($sformatf("R6 thr_hit cfg=%0d k=%0d", c, k), thr_hit, (k >= lvl_of(c)) ? 1 : 0);
        chk($sformatf("R5 full cfg=%0d k=%0d", c, k), full, (k == D + 1) ? 1 : 0);
      end
    end

    // R7 the 17th did not overrun, the 18th does
    chk("R7 no overrun at DEPTH+1", ovr, 0);
    put(9'h0AA, 3'b000);
    chk("R7 overrun on extra char", ovr, 1);
    chk("R7 still full", full, 1);

    // R2 R9 drain in order with errors following each character
    for (int i = 1; i <= D + 1; i++) begin
      chk($sformatf("R2 order i=%0d", i), rd_data, pat(i, 7));
      chk($sformatf("R9 errors i=%0d", i), {pe_flag, fe_flag, ne_flag}, i % 8);
      take();
    end
    chk("R7 discarded char absent", not_empty, 0);

    // R10 overrun clear
    clr_ore = 1'b1; tick(); clr_ore = 1'b0;
    chk("R10 clr_ore clears ovr", ovr, 0);

    // R8 overrun detection disabled
    thr_cfg = 3'd5;
    do_flush();
    for (int k = 1; k <= D + 1; k++) put(pat(k, 1), 3'b000);
    ovr_off = 1'b1;
    put(9'h1FF, 3'b000);
    chk("R8 ovr held low", ovr, 0);
    chk("R8 head kept", rd_data, pat(1, 1));
    ovr_off = 1'b0;
    put(9'h1FE, 3'b000);
    chk("R7 ovr sets when re-enabled", ovr, 1);
    clr_ore = 1'b1; tick(); clr_ore = 1'b0;

    // R3 simultaneous read and write
    do_flush();
    put(9'h101, 3'b000); put(9'h102, 3'b000); put(9'h103, 3'b000);
    rx_valid = 1'b1; rx_data = 9'h104; rd_en = 1'b1;
    tick();
    rx_valid = 1'b0; rd_en = 1'b0;
    chk("R3 head after rd+wr", rd_data, 9'h102);
    n = 0;
    for (int g = 0; g < 8 && not_empty; g++) begin
      take();
      n++;
    end
    chk("R3 count kept by rd+wr", n, 3);

    // R3 rd+wr with only the holding register occupied
    put(9'h011, 3'b000);
    rx_valid = 1'b1; rx_data = 9'h022; rd_en = 1'b1;
    tick();
    rx_valid = 1'b0; rd_en = 1'b0;
    chk("R3 passthrough data", rd_data, 9'h022);
    chk("R3 passthrough not_empty", not_empty, 1);
    take();

    // R3 read while empty
    keep = rd_data;
    take();
    chk("R3 empty read not_empty", not_empty, 0);
    chk("R3 empty read keeps data", rd_data, keep);

    // R4 flush
    put(9'h033, 3'b000); put(9'h044, 3'b000);
    do_flush();
    chk("R4 flush not_empty", not_empty, 0);
    chk("R4 flush full", full, 0);
    put(9'h066, 3'b000);
    take();
    chk("R4 storage empty after flush", not_empty, 0);

    // R10 individual error clears
    put(9'h055, 3'b111);
    chk("R9 all errors", {pe_flag, fe_flag, ne_flag}, 7);
    clr_pe = 1'b1; tick(); clr_pe = 1'b0;
    chk("R10 clr_pe only", {pe_flag, fe_flag, ne_flag}, 3);
    clr_fe = 1'b1; tick(); clr_fe = 1'b0;
    chk("R10 clr_fe only", {pe_flag, fe_flag, ne_flag}, 1);
    clr_ne = 1'b1; tick(); clr_ne = 1'b0;
    chk("R10 clr_ne only", {pe_flag, fe_flag, ne_flag}, 0);
    chk("R10 data untouched", rd_data, 9'h055);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule